// File: doc/BRIEF.md
# PHY Configuration and Media Status Register

This block is a single 32-bit host-visible register for a network controller that contains its own PHY. One part holds configuration that software may read and write. The other part reports the live state of the PHY: link, speed, duplex, 10 Mb/s polarity and auto-negotiation completion. These status bits are captured from the PHY every clock and cannot be written. At power-up, a serial EEPROM loader supplies the auto-negotiation select code and the pause advertise bit through a one-cycle valid strobe. Software can rewrite both values later.

The register turns the 3-bit auto-negotiation select code into PHY control outputs. Each code either forces one fixed speed and duplex, or enables auto-negotiation with a given set of advertised abilities. Pause is advertised only when at least one full-duplex ability is advertised. A control bit decides whether a host read of the interrupt status register also sends a one-cycle clear pulse to the PHY interrupt source. Setting the external PHY bit turns on the MII and also sets the internal PHY disable bit.

Top module: `phy_cfg_reg`

## Requirements
- R1: Hard reset (rst_n low, asynchronous) and soft reset (soft_rst high at a clock edge) both clear every stored configuration bit and the clear pulse to 0. Soft reset takes priority over a host write and over an EEPROM load in the same cycle.
- R2: Read bits 31..27 report, one clock after sampling, the PHY inputs in this order: link good (31), 100 Mb/s (30), full duplex (29), reversed polarity (28) and auto-negotiation done (27). Host writes to bits 31..27 are ignored.
- R3: Bit 28 reads 0 whenever the sampled 100 Mb/s input is 1, even when the raw polarity input reports reversal.
- R4: The select field occupies bits 15:13. When bit 13 is 0, auto-negotiation is off and all advertise outputs are 0. Bit 14 gives the forced speed (1 = 100 Mb/s) and bit 15 gives the forced duplex (1 = full).
- R5: When bit 13 is 1, auto-negotiation is on, the forced outputs are 0, and the advertised abilities are as follows. Code 001 advertises 10 half and 10 full. Code 011 advertises 10 half and 100 half. Code 101 advertises 100 half and 100 full. Code 111 advertises all four.
- R6: adv_pause equals bit 16 AND'ed with whether the current code advertises 10 full or 100 full.
- R7: When bit 17 is 1 at the edge where isr_rd is sampled high, irq_clr is high for exactly the following cycle. When bit 17 is 0, irq_clr stays low.
- R8: An ee_vld strobe loads ee_sel into bits 15:13 and ee_pause into bit 16. It wins over a same-cycle host write to those bits, while the remaining bits of that write still take effect.
- R9: Bit 12 drives mii_en. Whenever bit 12 is stored as 1, bit 9 is also stored as 1. Bit 9 drives int_phy_dis.
- R10: Bits 26:24 and bit 11 always read 0. Bits 23:18 (driven on phy_cfg_bits), 10 and 8:0 are plain read/write storage.
- R11: Only byte address CFG_OFFSET (default 0x004) selects the register. Writes to any other address change nothing, and reads of any other address return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous hard reset, active low |
| soft_rst | input | 1 | Synchronous soft reset |
| wr_en | input | 1 | Host write strobe |
| addr | input | ADDR_W | Host byte address |
| wdata | input | 32 | Host write data |
| rdata | output | 32 | Host read data, combinational from address |
| isr_rd | input | 1 | Host read of the interrupt status register |
| phy_link | input | 1 | PHY link good |
| phy_spd100 | input | 1 | PHY running at 100 Mb/s |
| phy_fdx | input | 1 | PHY running full duplex |
| phy_pol_rev | input | 1 | PHY raw reversed-polarity flag |
| phy_an_done | input | 1 | Auto-negotiation complete or inactive |
| ee_vld | input | 1 | EEPROM default load strobe |
| ee_sel | input | 3 | EEPROM select code |
| ee_pause | input | 1 | EEPROM pause advertise value |
| an_enable | output | 1 | Auto-negotiation enable to PHY |
| force_100 | output | 1 | Forced speed 100 Mb/s |
| force_fdx | output | 1 | Forced full duplex |
| adv_10hd | output | 1 | Advertise 10 half |
| adv_10fd | output | 1 | Advertise 10 full |
| adv_100hd | output | 1 | Advertise 100 half |
| adv_100fd | output | 1 | Advertise 100 full |
| adv_pause | output | 1 | Advertise pause |
| mii_en | output | 1 | MII enable for external PHY |
| int_phy_dis | output | 1 | Internal PHY disable |
| phy_cfg_bits | output | 6 | PHY power-on configuration bits |
| irq_clr | output | 1 | Clear pulse to PHY interrupt source |

## Verification
The bench walks all eight select codes, each with pause both set and clear. A decoder that reversed the speed and duplex bits, or that advertised pause on a half-duplex-only code such as 011, would show wrong control outputs. It reads polarity at both speeds, which catches a design that passes raw reversal through at 100 Mb/s. It strobes the interrupt-status read with the auto-clear bit on and off, and checks the cycle after as well, so a clear pulse that is missing, stretched or not gated is caught. It also collides an EEPROM load with a host write. Finally, it writes all ones to find reserved bits that stick, and writes to a foreign address to find decode leaks.

// File: rtl/phy_cfg_pkg.sv
package phy_cfg_pkg;

    localparam int DATA_W    = 32;
    localparam int PCFG_W    = 6;
    localparam int SEL_W     = 3;
    localparam int MISC_W    = 11;
    localparam int STS_W     = 5;
    localparam int IPD_BIT   = 9;

    // stored configuration fields
    typedef struct packed {
        logic [PCFG_W-1:0] phy_cfg;  // 23:18
        logic              acen;     // 17
        logic              pause;    // 16
        logic [SEL_W-1:0]  sel;      // 15:13
        logic              ext;      // 12
        logic [MISC_W-1:0] misc;     // 10:0
    } cfg_t;

    // captured PHY status, bit 31 down to 27
    typedef struct packed {
        logic link;
        logic spd;
        logic fdx;
        logic pol;
        logic an;
    } sts_t;

    // decoded auto-negotiation controls
    typedef struct packed {
        logic an_en;
        logic f100;
        logic ffdx;
        logic a10h;
        logic a10f;
        logic a100h;
        logic a100f;
        logic apause;
    } anctl_t;

    function automatic cfg_t word_to_cfg(input logic [DATA_W-1:0] w);
        cfg_t c;
        c.phy_cfg = w[23:18];
        c.acen    = w[17];
        c.pause   = w[16];
        c.sel     = w[15:13];
        c.ext     = w[12];
        c.misc    = w[10:0];
        return c;
    endfunction

    function automatic logic [DATA_W-1:0] cfg_to_word(input cfg_t c, input sts_t s);
        return {s, 3'b000, c.phy_cfg, c.acen, c.pause, c.sel, c.ext, 1'b0, c.misc};
    endfunction

endpackage

// File: rtl/phy_cfg_status.sv
module phy_cfg_status
    import phy_cfg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic link_i,
    input  logic spd_i,
    input  logic fdx_i,
    input  logic pol_i,
    input  logic an_i,
    output sts_t sts_o
);
    sts_t sts_d, sts_q;

    always_comb begin
        sts_d      = sts_q;
        sts_d.link = link_i;
        sts_d.spd  = spd_i;
        sts_d.fdx  = fdx_i;
        // reversal is only meaningful at 10 Mb/s
        sts_d.pol  = pol_i & ~spd_i;
        sts_d.an   = an_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sts_q <= '0;
        else        sts_q <= sts_d;
    end

    assign sts_o = sts_q;
endmodule

// File: rtl/phy_cfg_store.sv
module phy_cfg_store
    import phy_cfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic              wr_hit,
    input  logic [DATA_W-1:0] wdata,
    input  logic              ee_vld,
    input  logic [SEL_W-1:0]  ee_sel,
    input  logic              ee_pause,
    input  logic              isr_rd,
    output cfg_t              cfg_o,
    output logic              clr_o
);
    typedef struct packed {
        cfg_t cfg;
        logic clr;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_hit) begin
            st_d.cfg = word_to_cfg(wdata);
        end
        if (ee_vld) begin
            st_d.cfg.sel   = ee_sel;
            st_d.cfg.pause = ee_pause;
        end
        if (st_d.cfg.ext) begin
            st_d.cfg.misc[IPD_BIT] = 1'b1;
        end
        st_d.clr = isr_rd & st_q.cfg.acen;
        if (soft_rst) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cfg_o = st_q.cfg;
    assign clr_o = st_q.clr;
endmodule

// File: rtl/phy_cfg_anmap.sv
module phy_cfg_anmap
    import phy_cfg_pkg::*;
(
    input  logic [SEL_W-1:0] sel_i,
    input  logic             pause_i,
    output anctl_t           ctl_o
);
    always_comb begin
        ctl_o = '0;
        case (sel_i)
            3'b000: begin ctl_o.f100 = 1'b0; ctl_o.ffdx = 1'b0; end
            3'b010: begin ctl_o.f100 = 1'b1; ctl_o.ffdx = 1'b0; end
            3'b100: begin ctl_o.f100 = 1'b0; ctl_o.ffdx = 1'b1; end
            3'b110: begin ctl_o.f100 = 1'b1; ctl_o.ffdx = 1'b1; end
            3'b001: begin
                ctl_o.an_en = 1'b1;
                ctl_o.a10h  = 1'b1;
                ctl_o.a10f  = 1'b1;
            end
            3'b011: begin
                ctl_o.an_en = 1'b1;
                ctl_o.a10h  = 1'b1;
                ctl_o.a100h = 1'b1;
            end
            3'b101: begin
                ctl_o.an_en = 1'b1;
                ctl_o.a100h = 1'b1;
                ctl_o.a100f = 1'b1;
            end
            default: begin
                ctl_o.an_en = 1'b1;
                ctl_o.a10h  = 1'b1;
                ctl_o.a10f  = 1'b1;
                ctl_o.a100h = 1'b1;
                ctl_o.a100f = 1'b1;
            end
        endcase
        ctl_o.apause = pause_i & (ctl_o.a10f | ctl_o.a100f);
    end
endmodule

// File: rtl/phy_cfg_reg.sv
module phy_cfg_reg
    import phy_cfg_pkg::*;
#(
    parameter int                ADDR_W     = 12,
    parameter logic [ADDR_W-1:0] CFG_OFFSET = 12'h004
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              isr_rd,
    input  logic              phy_link,
    input  logic              phy_spd100,
    input  logic              phy_fdx,
    input  logic              phy_pol_rev,
    input  logic              phy_an_done,
    input  logic              ee_vld,
    input  logic [SEL_W-1:0]  ee_sel,
    input  logic              ee_pause,
    output logic              an_enable,
    output logic              force_100,
    output logic              force_fdx,
    output logic              adv_10hd,
    output logic              adv_10fd,
    output logic              adv_100hd,
    output logic              adv_100fd,
    output logic              adv_pause,
    output logic              mii_en,
    output logic              int_phy_dis,
    output logic [PCFG_W-1:0] phy_cfg_bits,
    output logic              irq_clr
);
    sts_t   sts_w;
    cfg_t   cfg_w;
    anctl_t ctl_w;
    logic   rd_hit;
    logic   acen_w;

    assign rd_hit = (addr == CFG_OFFSET);
    assign acen_w = cfg_w.acen;

    phy_cfg_status u_sts (
        .clk    (clk),
        .rst_n  (rst_n),
        .link_i (phy_link),
        .spd_i  (phy_spd100),
        .fdx_i  (phy_fdx),
        .pol_i  (phy_pol_rev),
        .an_i   (phy_an_done),
        .sts_o  (sts_w)
    );

    phy_cfg_store u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .soft_rst (soft_rst),
        .wr_hit   (wr_en & rd_hit),
        .wdata    (wdata),
        .ee_vld   (ee_vld),
        .ee_sel   (ee_sel),
        .ee_pause (ee_pause),
        .isr_rd   (isr_rd),
        .cfg_o    (cfg_w),
        .clr_o    (irq_clr)
    );

    phy_cfg_anmap u_map (
        .sel_i   (cfg_w.sel),
        .pause_i (cfg_w.pause),
        .ctl_o   (ctl_w)
    );

    assign rdata        = rd_hit ? cfg_to_word(cfg_w, sts_w) : '0;
    assign an_enable    = ctl_w.an_en;
    assign force_100    = ctl_w.f100;
    assign force_fdx    = ctl_w.ffdx;
    assign adv_10hd     = ctl_w.a10h;
    assign adv_10fd     = ctl_w.a10f;
    assign adv_100hd    = ctl_w.a100h;
    assign adv_100fd    = ctl_w.a100f;
    assign adv_pause    = ctl_w.apause;
    assign mii_en       = cfg_w.ext;
    assign int_phy_dis  = cfg_w.misc[IPD_BIT];
    assign phy_cfg_bits = cfg_w.phy_cfg;
endmodule

// File: rtl/phy_cfg_reg_chk.sv
module phy_cfg_reg_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        soft_rst,
    input logic        rd_hit,
    input logic [31:0] rdata,
    input logic        isr_rd,
    input logic        acen_w,
    input logic        irq_clr,
    input logic        an_enable,
    input logic        adv_10hd,
    input logic        adv_10fd,
    input logic        adv_100hd,
    input logic        adv_100fd,
    input logic        adv_pause,
    input logic        mii_en,
    input logic        int_phy_dis
);
    // R1
    soft_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(soft_rst) && rd_hit) |-> (rdata[26:0] == 27'd0));

    // R3
    pol_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_hit && rdata[30]) |-> !rdata[28]);

    // R4
    forced_no_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !an_enable |-> !(adv_10hd || adv_10fd || adv_100hd || adv_100fd || adv_pause));

    // R6
    pause_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        adv_pause |-> (adv_10fd || adv_100fd));

    // R7
    clr_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_clr |-> $past(isr_rd && acen_w));

    // R7
    clr_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (isr_rd && acen_w && !soft_rst) |=> irq_clr);

    // R9
    ext_forces_dis_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mii_en |-> int_phy_dis);

    // R10
    zero_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_hit |-> (rdata[26:24] == 3'd0 && !rdata[11]));

    // R11
    miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_hit |-> (rdata == 32'd0));
endmodule

bind phy_cfg_reg phy_cfg_reg_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .soft_rst    (soft_rst),
    .rd_hit      (rd_hit),
    .rdata       (rdata),
    .isr_rd      (isr_rd),
    .acen_w      (acen_w),
    .irq_clr     (irq_clr),
    .an_enable   (an_enable),
    .adv_10hd    (adv_10hd),
    .adv_10fd    (adv_10fd),
    .adv_100hd   (adv_100hd),
    .adv_100fd   (adv_100fd),
    .adv_pause   (adv_pause),
    .mii_en      (mii_en),
    .int_phy_dis (int_phy_dis)
);

// File: tb/phy_cfg_reg_tb.sv
module phy_cfg_reg_tb;
    localparam logic [11:0] OFF   = 12'h004;
    localparam logic [31:0] WMASK = 32'h00FF_F7FF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        soft_rst = 1'b0;
    logic        wr_en = 1'b0;
    logic [11:0] addr = OFF;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        isr_rd = 1'b0;
    logic        phy_link = 1'b0, phy_spd100 = 1'b0, phy_fdx = 1'b0;
    logic        phy_pol_rev = 1'b0, phy_an_done = 1'b0;
    logic        ee_vld = 1'b0;
    logic [2:0]  ee_sel = '0;
    logic        ee_pause = 1'b0;
    logic        an_enable, force_100, force_fdx;
    logic        adv_10hd, adv_10fd, adv_100hd, adv_100fd, adv_pause;
    logic        mii_en, int_phy_dis, irq_clr;
    logic [5:0]  phy_cfg_bits;

    int total = 0;
    int bad = 0;

    logic [31:0] mdl = '0;
    logic [4:0]  sts_exp = '0;
    logic        clr_exp = 1'b0;

    always #5 clk = ~clk;

    phy_cfg_reg u_dut (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .isr_rd(isr_rd),
        .phy_link(phy_link), .phy_spd100(phy_spd100), .phy_fdx(phy_fdx),
        .phy_pol_rev(phy_pol_rev), .phy_an_done(phy_an_done),
        .ee_vld(ee_vld), .ee_sel(ee_sel), .ee_pause(ee_pause),
        .an_enable(an_enable), .force_100(force_100), .force_fdx(force_fdx),
        .adv_10hd(adv_10hd), .adv_10fd(adv_10fd), .adv_100hd(adv_100hd),
        .adv_100fd(adv_100fd), .adv_pause(adv_pause), .mii_en(mii_en),
        .int_phy_dis(int_phy_dis), .phy_cfg_bits(phy_cfg_bits), .irq_clr(irq_clr)
    );

    // expected decode: {an_en, f100, ffdx, a10h, a10f, a100h, a100f, apause}
    function automatic logic [7:0] dec_exp(input logic [2:0] s, input logic p);
        logic a10h, a10f, a100h, a100f;
        if (!s[0]) return {1'b0, s[1], s[2], 5'b0};
        a10h  = (s != 3'b101);
        a10f  = (s == 3'b001) || (s == 3'b111);
        a100h = (s != 3'b001);
        a100f = (s == 3'b101) || (s == 3'b111);
        return {3'b100, a10h, a10f, a100h, a100f, p & (a10f | a100f)};
    endfunction

    function automatic logic [31:0] nxt_mdl(input logic [31:0] old);
        logic [31:0] n;
        if (soft_rst) return '0;
        n = old;
        if (wr_en && addr == OFF) n = wdata & WMASK;
        if (ee_vld) begin
            n[15:13] = ee_sel;
            n[16]    = ee_pause;
        end
        if (n[12]) n[9] = 1'b1;
        return n;
    endfunction

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    // one clock: advance model, then release strobes
    task automatic cyc();
        logic [31:0] n;
        logic        c;
        logic [4:0]  s;
        n = nxt_mdl(mdl);
        c = isr_rd & mdl[17] & ~soft_rst;
        s = {phy_link, phy_spd100, phy_fdx, phy_pol_rev & ~phy_spd100, phy_an_done};
        @(posedge clk);
        @(negedge clk);
        mdl = n; clr_exp = c; sts_exp = s;
        wr_en = 1'b0; ee_vld = 1'b0; isr_rd = 1'b0; soft_rst = 1'b0;
    endtask

    task automatic check_all(input string tag);
        addr = OFF;
        #1;
        chk({tag, " rdata"}, rdata, {sts_exp, mdl[26:0]});
        chk({tag, " decode"}, {24'd0, an_enable, force_100, force_fdx, adv_10hd,
            adv_10fd, adv_100hd, adv_100fd, adv_pause}, {24'd0, dec_exp(mdl[15:13], mdl[16])});
        chk({tag, " misc_out"}, {24'd0, mii_en, int_phy_dis, phy_cfg_bits},
            {24'd0, mdl[12], mdl[9], mdl[23:18]});
        chk({tag, " irq_clr"}, {31'd0, irq_clr}, {31'd0, clr_exp});
    endtask

    task automatic host_wr(input logic [31:0] d);
        addr = OFF; wdata = d; wr_en = 1'b1;
        cyc();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h1234_5678));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check_all("R1 hard reset");

        // R2: status capture, writes to 31:27 ignored
        phy_link = 1; phy_spd100 = 0; phy_fdx = 1; phy_an_done = 1;
        host_wr(32'hF800_0000);
        check_all("R2 status");

        // R3: polarity masked at 100 Mb/s
        phy_pol_rev = 1; phy_spd100 = 1;
        cyc(); check_all("R3 pol at 100");
        chk("R3 bit28 at 100", {31'd0, rdata[28]}, 32'd0);
        phy_spd100 = 0;
        cyc(); check_all("R3 pol at 10");
        chk("R3 bit28 at 10", {31'd0, rdata[28]}, 32'd1);

        // R4 R5 R6: every select code, pause on and off
        for (int code = 0; code < 8; code++) begin
            for (int p = 0; p < 2; p++) begin
                host_wr({15'd0, p[0], code[2:0], 13'd0});
                check_all(code[0] ? "R5 adv code" : "R4 forced code");
                chk("R6 pause gate", {31'd0, adv_pause},
                    {31'd0, p[0] & (code == 1 || code == 5 || code == 7)});
            end
        end

        // R8: EEPROM load beats host write on 16:13, rest of write applies
        addr = OFF; wdata = 32'h00FC_E005; wr_en = 1'b1;
        ee_vld = 1'b1; ee_sel = 3'b101; ee_pause = 1'b1;
        cyc(); check_all("R8 ee priority");
        chk("R8 sel field", {29'd0, rdata[15:13]}, 32'd5);

        // R9: external PHY forces internal disable
        host_wr(32'h0000_1000);
        check_all("R9 ext phy");
        chk("R9 bit9", {31'd0, rdata[9]}, 32'd1);

        // R10: reserved bits stay 0, storage bits hold
        host_wr(32'hFFFF_FFFF);
        check_all("R10 all ones");
        chk("R10 reserved", {28'd0, rdata[26:24], rdata[11]}, 32'd0);

        // R7: auto-clear pulse
        host_wr(32'h0002_0000);
        isr_rd = 1'b1; cyc(); check_all("R7 clr on");
        chk("R7 pulse", {31'd0, irq_clr}, 32'd1);
        cyc(); check_all("R7 clr one cycle");
        host_wr(32'h0000_0000);
        isr_rd = 1'b1; cyc(); check_all("R7 clr off");
        chk("R7 no pulse", {31'd0, irq_clr}, 32'd0);

        // R11: other address
        host_wr(32'h0012_3456);
        addr = 12'h008; wdata = 32'h00FF_FFFF; wr_en = 1'b1;
        cyc(); check_all("R11 foreign write");
        addr = 12'h000; #1;
        chk("R11 foreign read", rdata, 32'd0);

        // R1: soft reset wins over write and load
        addr = OFF; wdata = 32'h00FF_FFFF; wr_en = 1'b1; ee_vld = 1'b1; soft_rst = 1'b1;
        cyc(); check_all("R1 soft reset");

        // random traffic
        for (int i = 0; i < 600; i++) begin
            logic [31:0] r;
            r = $urandom;
            addr        = r[0] ? OFF : 12'($urandom);
            wr_en       = r[1] | r[2];
            wdata       = $urandom;
            ee_vld      = (r[7:3] == 0);
            ee_sel      = r[10:8];
            ee_pause    = r[11];
            isr_rd      = r[12];
            soft_rst    = (r[20:14] == 0);
            phy_link    = r[21]; phy_spd100 = r[22]; phy_fdx = r[23];
            phy_pol_rev = r[24]; phy_an_done = r[25];
            cyc();
            check_all("R2 R7 R8 random");
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule